// File: doc/BRIEF.md
# True-Color Pixel Unpacker with Overlay Gate

This block takes a 32-bit true-color input word and turns it into 8-bit red, green and blue values plus a palette index. A word holds either two 16-bit pixels (5-5-5 with one overlay bit, or 5-6-5 with no overlay bit) or one 24-bit pixel with an 8-bit overlay byte. The 24-bit pixel comes in one of two field orders, and one order is the exact reverse of the other. Short colour fields are left-justified, and the freed low bits are cleared. In the 5-5-5 format the single overlay bit becomes the LSB of an 8-bit overlay value. The upper seven bits of that value come from a palette page input.

The composed overlay is ANDed with a read mask. If the result is zero, the true-color values drive the outputs. Otherwise the block asserts a palette-select output and presents the masked overlay as the palette index. An 8/6 width select travels with each pixel so that a downstream palette mux can pick the matching data width. An endianness select controls two things: which 16-bit half of a pair is emitted first, and the byte order of a 24-bit word.

A two-state controller sequences the work. In `S_IDLE`, a valid 24-bit word produces one output pixel and the controller stays in `S_IDLE`. A valid 16-bit-pair word produces the first half and takes the transition `S_IDLE -> S_HOLD`. `S_HOLD` emits the stored second half and always returns with `S_HOLD -> S_IDLE`. Input is ignored while the controller is in `S_HOLD`.

Top module: `tc_pixel_unpack`

## Requirements
- R1: After reset, `out_valid`, `red`, `green`, `blue`, `pal_sel`, `pal_idx` and `pal_wide` are all zero.
- R2: Format 0 (5-5-5) places red from bits 14:10, green from 9:5 and blue from 4:0 of the 16-bit half into the top five bits of each output, with the low three bits zero.
- R3: Format 1 (5-6-5) places red from bits 15:11 into `red[7:3]`, green from bits 10:5 into `green[7:2]` and blue from bits 4:0 into `blue[7:3]`, with all lower bits zero. Its overlay value is zero.
- R4: In format 0 the overlay value is {page[6:0], half bit 15}.
- R5: The masked overlay is the overlay value AND `rmask`. When it is zero, the colours are output with `pal_sel`=0 and `pal_idx`=0. When it is nonzero, `pal_sel`=1, `pal_idx` holds the masked value and red, green and blue are zero. An `rmask` of zero always selects true color.
- R6: Format 3 takes overlay from bits 31:24, red from 23:16, green from 15:8 and blue from 7:0. Format 2 is the reverse: blue from 31:24, green from 23:16, red from 15:8 and overlay from 7:0.
- R7: In formats 0 and 1 with `big_end`=0, bits 15:0 are emitted first and bits 31:16 second. With `big_end`=1 the order is swapped. The two results appear after the first and second clock edges following acceptance.
- R8: In formats 2 and 3 with `big_end`=1, the 32-bit word is byte-reversed before the fields are extracted.
- R9: A 24-bit word yields exactly one output pixel, one cycle after acceptance. Any `in_valid` presented while the second half of a pair is pending is ignored.
- R10: `pal_wide` equals the `sel8` value captured with the pixel. `sel8` has no effect on the colour outputs.
- R11: `fmt`, `page`, `rmask` and `sel8` are sampled when a pair word is accepted, and they apply to both halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Packed true-color word |
| fmt | input | 2 | 0=5-5-5 pair, 1=5-6-5 pair, 2=24-bit reversed, 3=24-bit standard |
| big_end | input | 1 | Endianness select (1 = big-endian) |
| sel8 | input | 1 | Palette data width select (1 = 8-bit) |
| page | input | 7 | Palette page bits for the overlay MSBs |
| rmask | input | 8 | Read mask applied to the overlay |
| out_valid | output | 1 | Output pixel valid |
| red | output | 8 | Red value |
| green | output | 8 | Green value |
| blue | output | 8 | Blue value |
| pal_sel | output | 1 | Palette path selected |
| pal_idx | output | 8 | Masked overlay used as palette index |
| pal_wide | output | 1 | Width select travelling with the pixel |

## Verification
A 24-bit result, and the first half of a pair, are due one clock edge after the word is accepted. The second half of a pair is due one edge later, and a 24-bit word must leave `out_valid` low on the edge after its result. The bench drives inputs on the falling edge and drops `in_valid` on the next falling edge. It then samples the first result at that same falling edge and the second half one full cycle later. The tests for ignored input and held configuration change the inputs during the `S_HOLD` cycle. They then confirm that the second sample still matches the word and settings captured at acceptance.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int CW     = 8;
    localparam int WORD_W = 4 * CW;
    localparam int HALF_W = WORD_W / 2;
    localparam int PAGE_W = CW - 1;
    localparam int NBYTES = WORD_W / CW;

    typedef enum logic [1:0] {
        FMT_555   = 2'd0,
        FMT_565   = 2'd1,
        FMT_24REV = 2'd2,
        FMT_24STD = 2'd3
    } tc_fmt_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } tc_state_e;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
        logic [CW-1:0] ovl;
    } tc_pix_t;
endpackage

// File: rtl/tc_field_unpack.sv
module tc_field_unpack
    import tc_pkg::*;
(
    input  tc_fmt_e             fmt,
    input  logic                big_end,
    input  logic [WORD_W-1:0]   word,
    input  logic [HALF_W-1:0]   half,
    input  logic [PAGE_W-1:0]   page,
    output tc_pix_t             pix
);
    logic [WORD_W-1:0] swapped;
    logic [WORD_W-1:0] wsel;

    // byte reversal for big-endian 24-bit words
    for (genvar bi = 0; bi < NBYTES; bi++) begin : g_swap
        assign swapped[bi*CW +: CW] = word[(NBYTES-1-bi)*CW +: CW];
    end

    assign wsel = big_end ? swapped : word;

    always_comb begin
        pix = '0;
        unique case (fmt)
            FMT_555: begin
                pix.r   = {half[14:10], 3'b000};
                pix.g   = {half[9:5],   3'b000};
                pix.b   = {half[4:0],   3'b000};
                pix.ovl = {page, half[15]};
            end
            FMT_565: begin
                pix.r   = {half[15:11], 3'b000};
                pix.g   = {half[10:5],  2'b00};
                pix.b   = {half[4:0],   3'b000};
                pix.ovl = '0;
            end
            FMT_24STD: begin
                pix.ovl = wsel[31:24];
                pix.r   = wsel[23:16];
                pix.g   = wsel[15:8];
                pix.b   = wsel[7:0];
            end
            FMT_24REV: begin
                pix.b   = wsel[31:24];
                pix.g   = wsel[23:16];
                pix.r   = wsel[15:8];
                pix.ovl = wsel[7:0];
            end
            default: pix = '0;
        endcase
    end
endmodule

// File: rtl/tc_overlay_gate.sv
module tc_overlay_gate
    import tc_pkg::*;
(
    input  tc_pix_t         pix,
    input  logic [CW-1:0]   rmask,
    output logic [CW-1:0]   r_o,
    output logic [CW-1:0]   g_o,
    output logic [CW-1:0]   b_o,
    output logic            sel_o,
    output logic [CW-1:0]   idx_o
);
    logic [CW-1:0] masked;

    assign masked = pix.ovl & rmask;

    always_comb begin
        sel_o = |masked;
        if (sel_o) begin
            r_o   = '0;
            g_o   = '0;
            b_o   = '0;
            idx_o = masked;
        end else begin
            r_o   = pix.r;
            g_o   = pix.g;
            b_o   = pix.b;
            idx_o = '0;
        end
    end
endmodule

// File: rtl/tc_pixel_unpack.sv
module tc_pixel_unpack
    import tc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_word,
    input  logic [1:0]          fmt,
    input  logic                big_end,
    input  logic                sel8,
    input  logic [PAGE_W-1:0]   page,
    input  logic [CW-1:0]       rmask,
    output logic                out_valid,
    output logic [CW-1:0]       red,
    output logic [CW-1:0]       green,
    output logic [CW-1:0]       blue,
    output logic                pal_sel,
    output logic [CW-1:0]       pal_idx,
    output logic                pal_wide
);
    tc_state_e          state_q, state_d;
    logic [HALF_W-1:0]  hold_half_q;
    tc_fmt_e            hold_fmt_q;
    logic [PAGE_W-1:0]  hold_page_q;
    logic [CW-1:0]      hold_mask_q;
    logic               hold_s8_q;
    logic               short_q;

    tc_fmt_e            fmt_in;
    logic               pair_in;
    logic               take;
    logic [HALF_W-1:0]  src_half;
    tc_fmt_e            src_fmt;
    logic               src_big;
    logic [PAGE_W-1:0]  src_page;
    logic [CW-1:0]      src_mask;
    logic               src_s8;

    tc_pix_t            pix;
    logic [CW-1:0]      r_w, g_w, b_w, idx_w;
    logic               sel_w;

    assign fmt_in  = tc_fmt_e'(fmt);
    assign pair_in = ~fmt[1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (in_valid && pair_in) state_d = S_HOLD;
            S_HOLD: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // source selection for the pixel processed this cycle
    always_comb begin
        unique case (state_q)
            S_HOLD: begin
                take     = 1'b1;
                src_half = hold_half_q;
                src_fmt  = hold_fmt_q;
                src_big  = 1'b0;
                src_page = hold_page_q;
                src_mask = hold_mask_q;
                src_s8   = hold_s8_q;
            end
            default: begin
                take     = in_valid;
                src_half = big_end ? in_word[WORD_W-1:HALF_W] : in_word[HALF_W-1:0];
                src_fmt  = fmt_in;
                src_big  = big_end;
                src_page = page;
                src_mask = rmask;
                src_s8   = sel8;
            end
        endcase
    end

    // second-half context captured on acceptance of a pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_half_q <= '0;
            hold_fmt_q  <= FMT_555;
            hold_page_q <= '0;
            hold_mask_q <= '0;
            hold_s8_q   <= 1'b0;
        end else if (state_q == S_IDLE && in_valid && pair_in) begin
            hold_half_q <= big_end ? in_word[HALF_W-1:0] : in_word[WORD_W-1:HALF_W];
            hold_fmt_q  <= fmt_in;
            hold_page_q <= page;
            hold_mask_q <= rmask;
            hold_s8_q   <= sel8;
        end
    end

    tc_field_unpack u_unpack (
        .fmt     (src_fmt),
        .big_end (src_big),
        .word    (in_word),
        .half    (src_half),
        .page    (src_page),
        .pix     (pix)
    );

    tc_overlay_gate u_gate (
        .pix   (pix),
        .rmask (src_mask),
        .r_o   (r_w),
        .g_o   (g_w),
        .b_o   (b_w),
        .sel_o (sel_w),
        .idx_o (idx_w)
    );

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            red       <= '0;
            green     <= '0;
            blue      <= '0;
            pal_sel   <= 1'b0;
            pal_idx   <= '0;
            pal_wide  <= 1'b0;
            short_q   <= 1'b0;
        end else begin
            out_valid <= take;
            if (take) begin
                red      <= r_w;
                green    <= g_w;
                blue     <= b_w;
                pal_sel  <= sel_w;
                pal_idx  <= idx_w;
                pal_wide <= src_s8;
                short_q  <= ~src_fmt[1];
            end
        end
    end

    // a pair word yields two consecutive output beats
    assert_pair_two_beats_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && in_valid && pair_in) |=> out_valid ##1 out_valid);

    // no input in idle means no output next cycle
    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !in_valid) |=> !out_valid);

    // palette path blanks colours
    assert_pal_blanks_rgb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pal_sel) |-> (red == '0 && green == '0 && blue == '0 && pal_idx != '0));

    // true-color path carries a zero index
    assert_tc_zero_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pal_sel) |-> (pal_idx == '0));

    // short fields carry cleared low bits
    assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && short_q && !pal_sel) |-> (red[2:0] == 3'b000 && blue[2:0] == 3'b000 && green[1:0] == 2'b00));

    // hold state lasts exactly one cycle
    assert_hold_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD) |=> (state_q == S_IDLE));
endmodule

// File: tb/test_tc_pixel_unpack.sv
module test_tc_pixel_unpack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [1:0]  fmt = '0;
    logic        big_end = 1'b0;
    logic        sel8 = 1'b0;
    logic [6:0]  page = '0;
    logic [7:0]  rmask = '0;
    logic        out_valid, pal_sel, pal_wide;
    logic [7:0]  red, green, blue, pal_idx;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tc_pixel_unpack i_tc_pixel_unpack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .fmt(fmt), .big_end(big_end), .sel8(sel8), .page(page), .rmask(rmask),
        .out_valid(out_valid), .red(red), .green(green), .blue(blue),
        .pal_sel(pal_sel), .pal_idx(pal_idx), .pal_wide(pal_wide)
    );

    // reference model built from the requirements
    function automatic logic [32:0] model(input logic [31:0] w, input logic [1:0] m,
                                          input logic be, input logic second,
                                          input logic [6:0] pg, input logic [7:0] rm);
        logic [15:0] h;
        logic [31:0] x;
        logic [7:0]  r, g, b, o, mk;
        h = (second ^ be) ? w[31:16] : w[15:0];
        x = be ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        case (m)
            2'd0: begin r = {h[14:10],3'b0}; g = {h[9:5],3'b0}; b = {h[4:0],3'b0}; o = {pg, h[15]}; end
            2'd1: begin r = {h[15:11],3'b0}; g = {h[10:5],2'b0}; b = {h[4:0],3'b0}; o = 8'h00; end
            2'd3: begin o = x[31:24]; r = x[23:16]; g = x[15:8]; b = x[7:0]; end
            default: begin b = x[31:24]; g = x[23:16]; r = x[15:8]; o = x[7:0]; end
        endcase
        mk = o & rm;
        if (mk != 8'h00) return {24'h0, 1'b1, mk};
        return {r, g, b, 1'b0, 8'h00};
    endfunction

    task automatic check(input string tag, input logic [32:0] exp, input logic exp_wide);
        checks++;
        if (!out_valid || {red, green, blue, pal_sel, pal_idx} !== exp || pal_wide !== exp_wide) begin
            errors++;
            $display("FAIL %s got v=%b %h w=%b exp v=1 %h w=%b", tag, out_valid,
                     {red, green, blue, pal_sel, pal_idx}, pal_wide, exp, exp_wide);
        end
    endtask

    task automatic check_idle(input string tag);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s got out_valid=%b exp 0", tag, out_valid);
        end
    endtask

    task automatic drive(input logic [31:0] w, input logic [1:0] m, input logic be,
                         input logic s8, input logic [6:0] pg, input logic [7:0] rm);
        @(negedge clk);
        in_word = w; fmt = m; big_end = be; sel8 = s8; page = pg; rmask = rm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_pair(input string tag, input logic [31:0] w, input logic [1:0] m,
                            input logic be, input logic s8, input logic [6:0] pg, input logic [7:0] rm);
        drive(w, m, be, s8, pg, rm);
        check(tag, model(w, m, be, 1'b0, pg, rm), s8);
        @(negedge clk);
        check(tag, model(w, m, be, 1'b1, pg, rm), s8);
        @(negedge clk);
        check_idle(tag);
    endtask

    task automatic run_single(input string tag, input logic [31:0] w, input logic [1:0] m,
                              input logic be, input logic s8, input logic [7:0] rm);
        drive(w, m, be, s8, 7'h00, rm);
        check(tag, model(w, m, be, 1'b0, 7'h00, rm), s8);
        @(negedge clk);
        check_idle({tag, "/R9"});
    endtask

    task automatic t_reset();
        checks++;
        if (out_valid !== 1'b0 || red !== 8'h00 || green !== 8'h00 || blue !== 8'h00 ||
            pal_sel !== 1'b0 || pal_idx !== 8'h00 || pal_wide !== 1'b0) begin
            errors++;
            $display("FAIL R1 got %b %h %h %h %b %h %b exp all zero", out_valid, red, green, blue,
                     pal_sel, pal_idx, pal_wide);
        end
    endtask

    task automatic t_555();
        run_pair("R2", 32'h7BDE_2A55, 2'd0, 1'b0, 1'b0, 7'h00, 8'h00);
        run_pair("R2", 32'h1234_ABCD, 2'd0, 1'b0, 1'b0, 7'h7F, 8'h00);
    endtask

    task automatic t_overlay();
        run_pair("R4", 32'h8001_0001, 2'd0, 1'b0, 1'b0, 7'h55, 8'hFF);
        run_pair("R4", 32'h7FFF_FFFF, 2'd0, 1'b0, 1'b0, 7'h00, 8'hFF);
    endtask

    task automatic t_565();
        run_pair("R3", 32'hFFFF_F81F, 2'd1, 1'b0, 1'b0, 7'h7F, 8'hFF);
        run_pair("R3", 32'h07E0_A5A5, 2'd1, 1'b0, 1'b0, 7'h00, 8'h00);
    endtask

    task automatic t_mask();
        run_pair("R5", 32'h8000_8000, 2'd0, 1'b0, 1'b0, 7'h2A, 8'h0F);
        run_pair("R5", 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b0, 7'h7F, 8'h00);
        run_single("R5", 32'h3C11_2233, 2'd3, 1'b0, 1'b0, 8'hC3);
        run_single("R5", 32'h3C11_2233, 2'd3, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_24();
        run_single("R6", 32'h0011_2233, 2'd3, 1'b0, 1'b0, 8'hFF);
        run_single("R6", 32'hA1B2_C300, 2'd2, 1'b0, 1'b0, 8'hFF);
        run_single("R6", 32'hA1B2_C3D4, 2'd2, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_big24();
        run_single("R8", 32'h4433_2200, 2'd3, 1'b1, 1'b0, 8'hFF);
        run_single("R8", 32'h00C3_B2A1, 2'd2, 1'b1, 1'b0, 8'hFF);
    endtask

    task automatic t_pair_order();
        run_pair("R7", 32'h1111_2222, 2'd1, 1'b1, 1'b0, 7'h00, 8'h00);
        run_pair("R7", 32'h1111_2222, 2'd1, 1'b0, 1'b0, 7'h00, 8'h00);
    endtask

    task automatic t_sel8();
        run_single("R10", 32'h0055_AA33, 2'd3, 1'b0, 1'b1, 8'hFF);
        run_pair("R10", 32'h4321_8765, 2'd1, 1'b0, 1'b1, 7'h00, 8'h00);
    endtask

    task automatic t_ignore();
        logic [31:0] w0 = 32'h5A5A_1F1F;
        @(negedge clk);
        in_word = w0; fmt = 2'd0; big_end = 1'b0; sel8 = 1'b0; page = 7'h00; rmask = 8'h00;
        in_valid = 1'b1;
        @(negedge clk);
        check("R9", model(w0, 2'd0, 1'b0, 1'b0, 7'h00, 8'h00), 1'b0);
        in_word = 32'hFFFF_FFFF; fmt = 2'd3;          // presented during the pending half
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", model(w0, 2'd0, 1'b0, 1'b1, 7'h00, 8'h00), 1'b0);
        @(negedge clk);
        check_idle("R9");
    endtask

    task automatic t_cfg_hold();
        logic [31:0] w0 = 32'h8000_0421;
        @(negedge clk);
        in_word = w0; fmt = 2'd0; big_end = 1'b0; sel8 = 1'b1; page = 7'h01; rmask = 8'h00;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11", model(w0, 2'd0, 1'b0, 1'b0, 7'h01, 8'h00), 1'b1);
        page = 7'h7F; rmask = 8'hFF; sel8 = 1'b0; fmt = 2'd1; big_end = 1'b1;
        @(negedge clk);
        check("R11", model(w0, 2'd0, 1'b0, 1'b1, 7'h01, 8'h00), 1'b1);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_555();
        t_overlay();
        t_565();
        t_mask();
        t_24();
        t_big24();
        t_pair_order();
        t_sel8();
        t_ignore();
        t_cfg_hold();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule